// File: doc/BRIEF.md
# Dual-Mode Limit Timer Channel

One timer channel that a processor controls through four 32-bit word registers. It has two modes. In counter mode the channel counts tick pulses. The count sits in bits 30..9 of the counter word, so each tick adds 0x200 to the word. The count is compared against a programmable limit. On a match the count wraps to zero, the channel sets a sticky reached flag and raises a level interrupt. The interrupt stays high until software reads the limit register or rewrites it through the resetting address. A limit of zero turns the compare off, so the counter runs freely through its whole range.

In user mode the same four addresses see a 54-bit free-running timer. The upper 31 bits sit at one address and the lower 23 bits at another. Software starts and stops the timer through a run bit, and the timer never interrupts. A separate mode register outside this block drives `mode_user`. The `tick` input comes from an external 500 ns prescaler.

The register bus is a plain single-cycle strobe interface with no back-pressure. A write takes effect at the clock edge where `bus_wr` is high. `bus_rdata` is combinational from the current state and the address, so it is valid in the cycle `bus_rd` is high. A read side effect, the interrupt acknowledge, applies at that same edge. Neither direction ever stalls, so the bus needs no valid/ready pair.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the limit reads 0x0000_0000, the counter word reads 0x0000_0000, the status word reads 0x0000_0001 (running), `irq` is low and the channel is in counter mode.
- R2: In counter mode, each cycle with `tick` high adds one unit (0x200) to the counter word at index 1. Without `tick` the count holds. Bits 8..0 of the counter word always read zero.
- R3: In counter mode, a write to index 0 loads the limit from write-data bits 30..9, clears the count, clears the reached flag and drops `irq`. A read of index 0 returns the limit with bits 31 and 8..0 zero.
- R4: In counter mode with a nonzero limit, the tick that would bring the count to the limit instead reloads the count to zero. That same tick sets the reached flag (bit 31 of the index-1 read) and raises `irq`, both visible one cycle after the tick.
- R5: In counter mode, a read of index 0 clears the reached flag and drops `irq` at that edge. A read of index 1 leaves both unchanged.
- R6: In counter mode, a write to index 2 loads the limit and leaves the count unchanged. If the new limit is below the current count, no match happens on the way up.
- R7: In counter mode with a limit of zero, the count advances on every tick and wraps from 0x7FFF_FE00 to zero. The reached flag and `irq` stay low.
- R8: In counter mode, writes to index 1 and index 3 have no effect. The count, the status word and `irq` keep their values.
- R9: In user mode, index 0 reads and writes the upper 31 bits of the 54-bit timer in bits 30..0, and bit 31 reads zero. Index 1 reads and writes the lower 23 bits in bits 31..9, and bits 8..0 read zero. While running, the combined value steps by one per tick, carries from the lower word into the upper word, and wraps to zero after all ones.
- R10: In user mode, writing index 3 with bit 0 set starts the timer and with bit 0 clear stops it. A stopped timer ignores ticks. Reading index 3 returns the run state in bit 0.
- R11: `mode_user` is sampled each clock. At the first edge after it rises, `irq` and the reached flag clear and the timer stops with its count kept. While in user mode `irq` stays low.
- R12: At the first edge after `mode_user` falls, the count resets to zero and the channel runs again in counter mode. The limit keeps its earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle count-enable pulse from the prescaler |
| mode_user | input | 1 | 1 selects user mode, 0 selects counter mode |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (index 0 read acknowledges) |
| bus_addr | input | 2 | Word index: 0 limit / upper, 1 count / lower, 2 limit without reset, 3 run status |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word |
| irq | output | 1 | Level interrupt, high while the reached flag is set |

## Verification
A corrupted count shows on the very next index-1 read. It also moves the match by the size of the error, so `irq` rises early or late. A wrong limit or compare behaves the same way: the interrupt fires at the wrong tick, or never when the limit compare is lost. That shows within the limit's number of ticks. A reached flag that is stuck, or an acknowledge that fails, leaves `irq` high after the index-0 read, which shows one cycle later. Faults in the user-mode carry, the run bit or the mode transitions show up at the port as a wrong upper or lower word or a status bit after a single tick.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int DATA_W = 32;
  localparam int FRAC_W = 9;

  typedef enum logic [1:0] {
    SEL_LIMIT      = 2'd0,
    SEL_COUNT      = 2'd1,
    SEL_LIMIT_KEEP = 2'd2,
    SEL_RUN        = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic lim_rst;
    logic lim_keep;
    logic up_wr;
    logic low_wr;
    logic run_wr;
    logic lim_ack;
  } bus_ops_t;
endpackage

// File: rtl/tmr_bus_decode.sv
module tmr_bus_decode
  import tmr_pkg::*;
(
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [1:0] bus_addr,
  input  logic       user_q,
  input  logic       mode_chg,
  output bus_ops_t   ops
);
  reg_sel_e sel;
  logic     wr_ok, rd_ok;

  always_comb begin
    sel   = reg_sel_e'(bus_addr);
    wr_ok = bus_wr && !mode_chg;
    rd_ok = bus_rd && !mode_chg;
    ops.lim_rst  = wr_ok && !user_q && (sel == SEL_LIMIT);
    ops.lim_keep = wr_ok && !user_q && (sel == SEL_LIMIT_KEEP);
    ops.up_wr    = wr_ok &&  user_q && (sel == SEL_LIMIT);
    ops.low_wr   = wr_ok &&  user_q && (sel == SEL_COUNT);
    ops.run_wr   = wr_ok &&  user_q && (sel == SEL_RUN);
    ops.lim_ack  = rd_ok && !user_q && (sel == SEL_LIMIT);
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
  import tmr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAC_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 user_q,
  input  logic                 enter_user,
  input  logic                 leave_user,
  input  bus_ops_t             ops,
  input  logic [DW-1:0]        wdata,
  output logic [(2*DW-FW-2):0] cnt_q,
  output logic [DW-FW-2:0]     limit_q,
  output logic                 hit_q,
  output logic                 run_q
);
  localparam int CNT_W  = DW - 1 - FW;
  localparam int UP_W   = DW - 1;
  localparam int LOW_W  = DW - FW;
  localparam int WIDE_W = UP_W + LOW_W;
  localparam logic [CNT_W-1:0]  ONE_C = CNT_W'(1);
  localparam logic [WIDE_W-1:0] ONE_W = WIDE_W'(1);

  logic [CNT_W-1:0] cnt_fld, cnt_inc;
  logic             match;

  always_comb begin
    cnt_fld = cnt_q[CNT_W-1:0];
    cnt_inc = cnt_fld + ONE_C;
    match   = (limit_q != '0) && (cnt_inc == limit_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      limit_q <= '0;
      hit_q   <= 1'b0;
      run_q   <= 1'b1;
    end else if (enter_user) begin
      run_q <= 1'b0;
      hit_q <= 1'b0;
    end else if (leave_user) begin
      run_q <= 1'b1;
      hit_q <= 1'b0;
      cnt_q <= '0;
    end else if (user_q) begin
      if (ops.up_wr)
        cnt_q <= {wdata[UP_W-1:0], cnt_q[LOW_W-1:0]};
      else if (ops.low_wr)
        cnt_q <= {cnt_q[WIDE_W-1:LOW_W], wdata[DW-1:FW]};
      else if (run_q && tick)
        cnt_q <= cnt_q + ONE_W;
      if (ops.run_wr)
        run_q <= wdata[0];
    end else if (ops.lim_rst) begin
      limit_q <= wdata[DW-2:FW];
      cnt_q   <= '0;
      hit_q   <= 1'b0;
    end else begin
      if (ops.lim_keep)
        limit_q <= wdata[DW-2:FW];
      if (tick)
        cnt_q <= match ? '0 : {{(WIDE_W-CNT_W){1'b0}}, cnt_inc};
      if (tick && match)
        hit_q <= 1'b1;
      else if (ops.lim_ack)
        hit_q <= 1'b0;
    end
  end

  // R11: no interrupt while the channel is in user mode
  a_r11_user_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    user_q |-> !hit_q);

  // R10: a stopped user timer holds its value
  a_r10_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (user_q && !run_q && !ops.up_wr && !ops.low_wr && !leave_user) |=> $stable(cnt_q));

  // R7: with a zero limit the reached flag never rises
  a_r7_free_run_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_q && (limit_q == '0) && !hit_q) |=> !hit_q);

  // R3: a resetting limit write leaves a zero count and no flag
  a_r3_reset_write: assert property (@(posedge clk) disable iff (!rst_n)
    ops.lim_rst |=> ((cnt_q == '0) && !hit_q));

  // R2: in counter mode the count never leaves its 22-bit field
  a_r2_field_bound: assert property (@(posedge clk) disable iff (!rst_n)
    !user_q |-> (cnt_q[WIDE_W-1:CNT_W] == '0));

  // R4: a matching tick reloads zero and sets the flag
  a_r4_match_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (!user_q && !enter_user && tick && !ops.lim_rst && match) |=> (hit_q && (cnt_q == '0)));
endmodule

// File: rtl/tmr_read_mux.sv
module tmr_read_mux
  import tmr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAC_W
) (
  input  logic [1:0]           bus_addr,
  input  logic                 user_q,
  input  logic [(2*DW-FW-2):0] cnt_q,
  input  logic [DW-FW-2:0]     limit_q,
  input  logic                 hit_q,
  input  logic                 run_q,
  output logic [DW-1:0]        rdata
);
  localparam int CNT_W  = DW - 1 - FW;
  localparam int LOW_W  = DW - FW;
  localparam int WIDE_W = 2 * DW - FW - 1;

  always_comb begin
    unique case (reg_sel_e'(bus_addr))
      SEL_LIMIT:
        rdata = user_q ? {1'b0, cnt_q[WIDE_W-1:LOW_W]}
                       : {1'b0, limit_q, {FW{1'b0}}};
      SEL_COUNT:
        rdata = user_q ? {cnt_q[LOW_W-1:0], {FW{1'b0}}}
                       : {hit_q, cnt_q[CNT_W-1:0], {FW{1'b0}}};
      SEL_LIMIT_KEEP:
        rdata = '0;
      default:
        rdata = {{(DW-1){1'b0}}, run_q};
    endcase
  end
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import tmr_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int FW = FRAC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          mode_user,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          irq
);
  localparam int WIDE_W = 2 * DW - FW - 1;
  localparam int CNT_W  = DW - 1 - FW;

  logic              user_q, enter_user, leave_user, mode_chg;
  bus_ops_t          ops;
  logic [WIDE_W-1:0] cnt_q;
  logic [CNT_W-1:0]  limit_q;
  logic              hit_q, run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) user_q <= 1'b0;
    else        user_q <= mode_user;
  end

  always_comb begin
    enter_user = mode_user && !user_q;
    leave_user = !mode_user && user_q;
    mode_chg   = enter_user || leave_user;
  end

  tmr_bus_decode u_dec (
    .bus_wr   (bus_wr),
    .bus_rd   (bus_rd),
    .bus_addr (bus_addr),
    .user_q   (user_q),
    .mode_chg (mode_chg),
    .ops      (ops)
  );

  tmr_count_core #(.DW(DW), .FW(FW)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .user_q     (user_q),
    .enter_user (enter_user),
    .leave_user (leave_user),
    .ops        (ops),
    .wdata      (bus_wdata),
    .cnt_q      (cnt_q),
    .limit_q    (limit_q),
    .hit_q      (hit_q),
    .run_q      (run_q)
  );

  tmr_read_mux #(.DW(DW), .FW(FW)) u_rmux (
    .bus_addr (bus_addr),
    .user_q   (user_q),
    .cnt_q    (cnt_q),
    .limit_q  (limit_q),
    .hit_q    (hit_q),
    .run_q    (run_q),
    .rdata    (bus_rdata)
  );

  assign irq = hit_q;

  // R11/R12: the registered mode follows the input one edge later
  a_r12_mode_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_user != user_q) |=> (user_q == $past(mode_user)));

  // R12: leaving user mode restarts the counter running from zero
  a_r12_leave_restart: assert property (@(posedge clk) disable iff (!rst_n)
    leave_user |=> (run_q && (cnt_q == '0)));
endmodule

// File: tb/test_dual_mode_timer.sv
module test_dual_mode_timer;
  logic        clk = 1'b0;
  logic        rst_n, tick, mode_user, bus_wr, bus_rd;
  logic [1:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  dual_mode_timer i_dual_mode_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_user(mode_user),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic set_mode(logic m);
    @(negedge clk); mode_user = m;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(2'd0, v); chk("R1 limit", v, 32'h0);
    rd(2'd1, v); chk("R1 count", v, 32'h0);
    rd(2'd3, v); chk("R1 status", v, 32'h1);
    chk("R1 irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_count;
    logic [31:0] v;
    ticks(3);
    rd(2'd1, v); chk("R2 three ticks", v, 32'h600);
    repeat (5) @(negedge clk);
    rd(2'd1, v); chk("R2 hold without tick", v, 32'h600);
  endtask

  task automatic t_limit;
    logic [31:0] v;
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R3 limit mask", v, 32'h7FFF_FE00);
    rd(2'd1, v); chk("R3 count reset", v, 32'h0);
    wr(2'd0, 32'h0000_0A37);
    ticks(4);
    rd(2'd1, v); chk("R4 before match", v, 32'h800);
    chk("R4 irq low before", {31'b0, irq}, 32'h0);
    ticks(1);
    chk("R4 irq on match", {31'b0, irq}, 32'h1);
    rd(2'd1, v); chk("R4 reached and reload", v, 32'h8000_0000);
    chk("R5 count read keeps irq", {31'b0, irq}, 32'h1);
    rd(2'd0, v); chk("R3 limit readback", v, 32'h0000_0A00);
    chk("R5 limit read acks", {31'b0, irq}, 32'h0);
    rd(2'd1, v); chk("R5 flag cleared", v, 32'h0);
    ticks(5);
    chk("R4 second match", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0600);
    chk("R3 write drops irq", {31'b0, irq}, 32'h0);
    rd(2'd1, v); chk("R3 write clears count", v, 32'h0);
  endtask

  task automatic t_keep;
    logic [31:0] v;
    ticks(2);
    wr(2'd2, 32'h0000_1000);
    rd(2'd1, v); chk("R6 count kept", v, 32'h400);
    rd(2'd0, v); chk("R6 new limit", v, 32'h1000);
    ticks(5);
    rd(2'd1, v); chk("R6 count before match", v, 32'hE00);
    ticks(1);
    chk("R6 match at new limit", {31'b0, irq}, 32'h1);
    rd(2'd0, v);
    ticks(3);
    wr(2'd2, 32'h0000_0400);
    ticks(2);
    rd(2'd1, v); chk("R6 limit below count passes", v, 32'hA00);
    chk("R6 no irq below count", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_free;
    logic [31:0] v;
    wr(2'd0, 32'h0);
    ticks(10);
    rd(2'd1, v); chk("R7 free-run count", v, 32'h1400);
    chk("R7 no irq", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_ignored;
    logic [31:0] v;
    wr(2'd1, 32'h1234_5600);
    wr(2'd3, 32'h0);
    rd(2'd1, v); chk("R8 count unchanged", v, 32'h1400);
    rd(2'd3, v); chk("R8 still running", v, 32'h1);
    ticks(1);
    rd(2'd1, v); chk("R8 keeps counting", v, 32'h1600);
  endtask

  task automatic t_user;
    logic [31:0] v;
    wr(2'd0, 32'h0000_0200);
    ticks(1);
    chk("R4 one-unit limit", {31'b0, irq}, 32'h1);
    set_mode(1'b1);
    chk("R11 entry drops irq", {31'b0, irq}, 32'h0);
    rd(2'd3, v); chk("R11 entry stops", v, 32'h0);
    ticks(3);
    rd(2'd1, v); chk("R10 stopped lower", v, 32'h0);
    rd(2'd0, v); chk("R10 stopped upper", v, 32'h0);
    wr(2'd0, 32'h0000_0001);
    wr(2'd1, 32'hFFFF_FE00);
    rd(2'd0, v); chk("R9 upper load", v, 32'h1);
    rd(2'd1, v); chk("R9 lower load", v, 32'hFFFF_FE00);
    wr(2'd3, 32'h1);
    rd(2'd3, v); chk("R10 started", v, 32'h1);
    ticks(1);
    rd(2'd0, v); chk("R9 carry upper", v, 32'h2);
    rd(2'd1, v); chk("R9 carry lower", v, 32'h0);
    ticks(2);
    rd(2'd1, v); chk("R9 lower steps", v, 32'h400);
    wr(2'd3, 32'h0);
    ticks(3);
    rd(2'd1, v); chk("R10 stop holds", v, 32'h400);
    chk("R11 no irq in user", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R9 upper bit31 zero", v, 32'h7FFF_FFFF);
    wr(2'd1, 32'hFFFF_FFFF);
    wr(2'd3, 32'h1);
    ticks(1);
    rd(2'd0, v); chk("R9 wrap upper", v, 32'h0);
    rd(2'd1, v); chk("R9 wrap lower", v, 32'h0);
    ticks(1);
    rd(2'd1, v); chk("R9 after wrap", v, 32'h200);
    chk("R11 irq stays low", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_leave;
    logic [31:0] v;
    set_mode(1'b0);
    rd(2'd1, v); chk("R12 count reset", v, 32'h0);
    rd(2'd3, v); chk("R12 running", v, 32'h1);
    rd(2'd0, v); chk("R12 limit kept", v, 32'h200);
    ticks(1);
    chk("R12 counts against kept limit", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; tick = 1'b0; mode_user = 1'b0;
    bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = 2'd0; bus_wdata = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_limit();
    t_keep();
    t_free();
    t_ignored();
    t_user();
    t_leave();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule